// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static memory that holds 32-bit words in four byte lanes. The host issues one request at a time on a valid/ready handshake. The request carries a direction, a 21-bit word address, write data and a four-bit lane mask. The controller latches the request and holds the address and write data steady. It then plays out a fixed sequence of strobes on the memory pins: one active-low select per lane, one shared active-low write enable and one shared active-low output enable.

Each minimum interval of the memory is given in nanoseconds. Each one is turned into a clock-cycle count from a clock-period parameter, rounding up, with no interval shorter than one cycle. The block can therefore be retargeted to a new clock without any change to the logic.

A write is the overlap of the selected lane strobes and write enable. Write enable always rises first, which ends the write. The selects and the data driver are then held for one more cycle. A read asserts the lane selects and output enable with write enable high. The data bus is sampled on the edge that closes the access window. The word is returned with a one-cycle valid pulse, and bytes whose lane was not selected are forced to zero. The handshake stays closed until the cycle time of the access, plus any bus turnaround, has run out.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every lane select, write enable and output enable is high, the data driver is off, `rd_valid` is low and `req_ready` is high.
- R2: Each timing interval is converted to a cycle count equal to ceil(ns / CLK_NS), with a minimum of one cycle.
- R3: A write holds write enable low, with the selected lanes low, for PULSE cycles. PULSE is the largest of the converted write-pulse, select-to-end, address-to-end and data-setup intervals. The address and write data do not change while any select is low or the data driver is on.
- R4: A write is ended by write enable rising. On that cycle the lane selects stay unchanged and the data driver stays on. Both are released on the next cycle. The data driver is on only during the write-enable-low cycles and this single hold cycle.
- R5: Lane i's select (`mem_cs_n[i]`) goes low only when `req_lanes[i]` was 1 in the accepted request. Lane i carries data bits 8i+7..8i. Memory bytes in unselected lanes keep their contents after a write.
- R6: A read holds output enable and the selected lanes low, with write enable high and the data driver off, for ACC cycles. ACC is the largest of the converted address-access, select-access and output-enable-access intervals. Write enable and output enable are never low together.
- R7: Read data is captured on the clock edge that ends the ACC window, so `rd_valid` is high for exactly one cycle, ACC+1 cycles after the accept edge. In `rd_data`, bytes of unselected lanes are zero.
- R8: After a read, all strobes stay high for max(RC - ACC, HZ) cycles before `req_ready` returns. RC is the converted read-cycle interval and HZ is the converted output-float interval.
- R9: `req_ready` is low from the accept edge until the access finishes. A write lasts max(PULSE + 1, WC) cycles, where WC is the converted write-cycle interval. A read lasts ACC + max(RC - ACC, HZ) cycles.
- R10: An access with an all-zero lane mask asserts no select but keeps the same timing. A read of this kind returns zero.
- R11: A request presented while `req_ready` is low is ignored. It changes no memory word and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 32 | Write data |
| req_lanes | input | 4 | Byte-lane mask, bit i selects bits 8i+7..8i |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 32 | Read data, unselected lanes zero |
| mem_addr | output | 21 | Memory address |
| mem_dq_out | output | 32 | Data driven towards the memory |
| mem_dq_oe | output | 1 | Enable for the external data driver |
| mem_dq_in | input | 32 | Data returned by the memory |
| mem_cs_n | output | 4 | Active-low lane selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
The bench builds the block with a 5 ns period and raises the write-cycle minimum to 30 ns, leaving every other interval at its default. This gives a write pulse of 3 cycles, a read access of 4 cycles and a 2-cycle read turnaround. The larger write-cycle minimum also makes the write-recovery phase reachable, which the default values would leave idle. The memory model withholds valid data until 4 cycles after the read strobes assert. An early capture therefore returns a poison pattern, and masked lanes return a non-zero filler that the controller must clear.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WR_PULSE  = 3'd1,
    ST_WR_HOLD   = 3'd2,
    ST_WR_RECOV  = 3'd3,
    ST_RD_ACCESS = 3'd4,
    ST_RD_RECOV  = 3'd5
  } seq_state_t;

  // R2: round an interval up to whole clock periods, at least one
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  // a load of N keeps the phase alive for N cycles
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int CNT_W     = 3,
  parameter int PULSE_CYC = 3,
  parameter int WC_REM    = 0,
  parameter int ACC_CYC   = 4,
  parameter int RREC_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [LANES-1:0] req_lanes,
  input  logic             timer_done,
  output logic             req_ready,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             cap_en,
  output logic [LANES-1:0] lanes_q,
  output logic [LANES-1:0] cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  seq_state_t       state_q, state_d;
  logic [LANES-1:0] lanes_d;
  logic [LANES-1:0] cs_n_d;
  logic             we_n_d, oe_n_d, dq_oe_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cap_en    = (state_q == ST_RD_ACCESS) && timer_done;
  assign lanes_d   = accept ? req_lanes : lanes_q;

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          timer_load = 1'b1;
          if (req_we) begin
            state_d   = ST_WR_PULSE;
            timer_val = CNT_W'(PULSE_CYC);
          end else begin
            state_d   = ST_RD_ACCESS;
            timer_val = CNT_W'(ACC_CYC);
          end
        end
      end
      ST_WR_PULSE: begin
        if (timer_done) begin
          state_d    = ST_WR_HOLD;
          timer_load = 1'b1;
          timer_val  = CNT_W'(1);
        end
      end
      ST_WR_HOLD: begin
        if (timer_done) begin
          if (WC_REM > 0) begin
            state_d    = ST_WR_RECOV;
            timer_load = 1'b1;
            timer_val  = CNT_W'(WC_REM);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_WR_RECOV: begin
        if (timer_done) state_d = ST_IDLE;
      end
      ST_RD_ACCESS: begin
        if (timer_done) begin
          state_d    = ST_RD_RECOV;
          timer_load = 1'b1;
          timer_val  = CNT_W'(RREC_CYC);
        end
      end
      ST_RD_RECOV: begin
        if (timer_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes decoded from the next state so pins come straight from flops
  always_comb begin
    cs_n_d  = '1;
    we_n_d  = 1'b1;
    oe_n_d  = 1'b1;
    dq_oe_d = 1'b0;
    unique case (state_d)
      ST_WR_PULSE: begin
        cs_n_d  = ~lanes_d;
        we_n_d  = 1'b0;
        dq_oe_d = 1'b1;
      end
      ST_WR_HOLD: begin
        cs_n_d  = ~lanes_d;
        dq_oe_d = 1'b1;
      end
      ST_RD_ACCESS: begin
        cs_n_d = ~lanes_d;
        oe_n_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lanes_q <= '0;
      cs_n    <= '1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      lanes_q <= lanes_d;
      cs_n    <= cs_n_d;
      we_n    <= we_n_d;
      oe_n    <= oe_n_d;
      dq_oe   <= dq_oe_d;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [LANES-1:0]        lanes,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic                    rd_valid,
  output logic [LANES*LANE_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= cap_en;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_data[l*LANE_W +: LANE_W] <= '0;
      end else if (cap_en) begin
        rd_data[l*LANE_W +: LANE_W] <= lanes[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_WC_NS   = 20,
  parameter int T_PWE_NS  = 15,
  parameter int T_SCS_NS  = 15,
  parameter int T_AW_NS   = 15,
  parameter int T_SD_NS   = 12,
  parameter int T_RC_NS   = 20,
  parameter int T_AA_NS   = 20,
  parameter int T_ACS_NS  = 20,
  parameter int T_DOE_NS  = 12,
  parameter int T_HZ_NS   = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_lanes,
  output logic                    rd_valid,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_in,
  output logic [LANES-1:0]        mem_cs_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n
);

  localparam int DATA_W    = LANES * LANE_W;
  localparam int PULSE_CYC = imax(imax(ns_to_cycles(T_PWE_NS, CLK_NS), ns_to_cycles(T_SCS_NS, CLK_NS)),
                                  imax(ns_to_cycles(T_AW_NS, CLK_NS),  ns_to_cycles(T_SD_NS, CLK_NS)));
  localparam int WC_CYC    = ns_to_cycles(T_WC_NS, CLK_NS);
  localparam int WC_REM    = imax(WC_CYC - PULSE_CYC - 1, 0);
  localparam int ACC_CYC   = imax(imax(ns_to_cycles(T_AA_NS, CLK_NS), ns_to_cycles(T_ACS_NS, CLK_NS)),
                                  ns_to_cycles(T_DOE_NS, CLK_NS));
  localparam int RC_CYC    = ns_to_cycles(T_RC_NS, CLK_NS);
  localparam int HZ_CYC    = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int RREC_CYC  = imax(RC_CYC - ACC_CYC, HZ_CYC);
  localparam int MAX_CYC   = imax(imax(PULSE_CYC, WC_REM), imax(ACC_CYC, RREC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1) + 1;

  // internal events, named for the checker
  logic             access_accept;
  logic             read_capture;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_done;
  logic [LANES-1:0] lanes_q;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (access_accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (timer_done)
  );

  sram_seq_fsm #(
    .LANES     (LANES),
    .CNT_W     (CNT_W),
    .PULSE_CYC (PULSE_CYC),
    .WC_REM    (WC_REM),
    .ACC_CYC   (ACC_CYC),
    .RREC_CYC  (RREC_CYC)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_lanes  (req_lanes),
    .timer_done (timer_done),
    .req_ready  (req_ready),
    .accept     (access_accept),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .cap_en     (read_capture),
    .lanes_q    (lanes_q),
    .cs_n       (mem_cs_n),
    .we_n       (mem_we_n),
    .oe_n       (mem_oe_n),
    .dq_oe      (mem_dq_oe)
  );

  sram_rd_capture #(.LANES(LANES), .LANE_W(LANE_W)) i_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (read_capture),
    .lanes    (lanes_q),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/sram_lane_chk.sv
`timescale 1ns/1ps
module sram_lane_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              read_capture,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic [LANES-1:0]  mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n == '1 && mem_we_n && mem_oe_n && !mem_dq_oe)); // R9
  AST_NO_ENABLE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n || mem_oe_n)); // R6
  AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R6
  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe); // R4
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_cs_n) && mem_dq_oe)); // R4
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> (mem_cs_n == '1 && !mem_dq_oe)); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1 && $past(mem_cs_n != '1)) |-> $stable(mem_addr)); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7
  AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    read_capture |-> (!mem_oe_n && mem_we_n)); // R7

endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (LANES*LANE_W),
  .LANES  (LANES)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rd_valid     (rd_valid),
  .read_capture (read_capture),
  .mem_addr     (mem_addr),
  .mem_dq_out   (mem_dq_out),
  .mem_dq_oe    (mem_dq_oe),
  .mem_cs_n     (mem_cs_n),
  .mem_we_n     (mem_we_n),
  .mem_oe_n     (mem_oe_n)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

  localparam int CLK_NS = 5;
  localparam int WC_NS  = 30;

  function automatic int to_clk(input int ns);
    int c;
    c = ns / CLK_NS;
    if (c * CLK_NS < ns) c = c + 1;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int bigger(input int a, input int b);
    return (a >= b) ? a : b;
  endfunction

  // R2: expected cycle counts restated from the interval table
  localparam int EXP_PULSE   = 3;
  localparam int EXP_ACC     = 4;
  int exp_wr_busy, exp_rd_busy;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_lanes = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [20:0] mem_addr;
  logic [31:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [31:0] mem_dq_in = 32'hBAD0_BAD0;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n;
  logic        mem_oe_n;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK_NS), .T_WC_NS(WC_NS)) i_sram_lane_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_we, .req_addr, .req_wdata,
    .req_lanes, .rd_valid, .rd_data, .mem_addr, .mem_dq_out, .mem_dq_oe,
    .mem_dq_in, .mem_cs_n, .mem_we_n, .mem_oe_n
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural memory and strobe monitor
  logic [31:0] model_mem [int];
  logic [31:0] shadow    [int];
  logic [3:0]  prv_cs = '1;
  logic        prv_we = 1'b1, prv_oe = 1'b1;
  logic [20:0] prv_addr = '0;
  logic [31:0] prv_dout = '0;
  int          we_lo_cnt = 0, oe_lo_cnt = 0, rd_cnt = 0;
  int          last_we_width = -1, last_oe_width = -1;
  logic [3:0]  last_wr_cs = '1, last_rd_cs = '1;
  bit          last_end_ok = 0, excl_bad = 0;

  function automatic logic [31:0] rd_word(input logic [31:0] arr [int], input int k);
    return arr.exists(k) ? arr[k] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 4; l++) begin
        if (!prv_cs[l] && !prv_we && !(!mem_cs_n[l] && !mem_we_n)) begin
          logic [31:0] w;
          w = rd_word(model_mem, int'(prv_addr));
          w[l*8 +: 8] = prv_dout[l*8 +: 8];
          model_mem[int'(prv_addr)] = w;
        end
      end
      if (!mem_we_n) we_lo_cnt++;
      if (!prv_we && mem_we_n) begin
        last_we_width = we_lo_cnt;
        last_wr_cs    = prv_cs;
        last_end_ok   = (mem_cs_n == prv_cs) && mem_dq_oe;
        we_lo_cnt     = 0;
      end
      if (!mem_oe_n) begin
        oe_lo_cnt++;
        last_rd_cs = mem_cs_n;
        if (mem_dq_oe) excl_bad = 1;
      end
      if (!prv_oe && mem_oe_n) begin
        last_oe_width = oe_lo_cnt;
        oe_lo_cnt = 0;
      end
      if (!mem_oe_n && !mem_we_n) excl_bad = 1;
      if (!mem_oe_n && mem_we_n && mem_cs_n != '1) rd_cnt++;
      else rd_cnt = 0;
      if (rd_cnt >= EXP_ACC) begin
        logic [31:0] v;
        v = rd_word(model_mem, int'(mem_addr));
        for (int l = 0; l < 4; l++)
          if (mem_cs_n[l]) v[l*8 +: 8] = 8'hA5;
        mem_dq_in = v;
      end else begin
        mem_dq_in = 32'hBAD0_BAD0;
      end
    end
    prv_cs   = mem_cs_n;
    prv_we   = mem_we_n;
    prv_oe   = mem_oe_n;
    prv_addr = mem_addr;
    prv_dout = mem_dq_out;
  end

  task automatic do_write(input logic [20:0] a, input logic [31:0] d, input logic [3:0] ln, input bit inject);
    int k;
    while (!req_ready) @(negedge clk);
    last_we_width = -1;
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d; req_lanes = ln;
    @(negedge clk);
    req_valid = 0;
    k = 1;
    while (!req_ready && k < 60) begin
      if (inject && k == 2) begin
        req_valid = 1; req_we = 1; req_addr = 21'd6; req_wdata = 32'hFFFF_0000; req_lanes = 4'hF;
      end else begin
        req_valid = 0;
      end
      @(negedge clk);
      k++;
    end
    req_valid = 0;
    chk(k == exp_wr_busy + 1, "R9 write busy cycles", 32'(k), 32'(exp_wr_busy + 1));
    chk(last_we_width == EXP_PULSE, "R3 write-enable low cycles", 32'(last_we_width), 32'(EXP_PULSE));
    chk(last_end_ok, "R4 select and data held when write enable rises", 32'(last_end_ok), 32'd1);
    chk(last_wr_cs == ~ln, "R5 write lane selects", 32'(last_wr_cs), 32'(~ln));
    begin
      logic [31:0] w;
      w = rd_word(shadow, int'(a));
      for (int l = 0; l < 4; l++) if (ln[l]) w[l*8 +: 8] = d[l*8 +: 8];
      shadow[int'(a)] = w;
    end
  endtask

  task automatic do_read(input logic [20:0] a, input logic [3:0] ln, input string tag);
    int k, vcnt, vat;
    logic [31:0] got, exp;
    while (!req_ready) @(negedge clk);
    excl_bad = 0; last_oe_width = -1;
    req_valid = 1; req_we = 0; req_addr = a; req_lanes = ln;
    @(negedge clk);
    req_valid = 0;
    k = 1; vcnt = 0; vat = -1; got = '0;
    while (!req_ready && k < 60) begin
      if (rd_valid) begin vcnt++; vat = k; got = rd_data; end
      @(negedge clk);
      k++;
    end
    exp = rd_word(shadow, int'(a));
    for (int l = 0; l < 4; l++) if (!ln[l]) exp[l*8 +: 8] = 8'h00;
    chk(vcnt == 1 && vat == EXP_ACC + 1, "R7 single valid pulse at access end", 32'(vat), 32'(EXP_ACC + 1));
    chk(got == exp, {tag, " read data with lane mask"}, got, exp);
    chk(k == exp_rd_busy + 1, "R8 read busy including turnaround", 32'(k), 32'(exp_rd_busy + 1));
    chk(last_oe_width == EXP_ACC && !excl_bad, "R6 output enable window", 32'(last_oe_width), 32'(EXP_ACC));
    chk(last_rd_cs == ~ln, "R5 read lane selects", 32'(last_rd_cs), 32'(~ln));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [20:0] pool [8];
    exp_wr_busy = bigger(EXP_PULSE + 1, to_clk(WC_NS));
    exp_rd_busy = EXP_ACC + bigger(to_clk(20) - EXP_ACC, to_clk(10));
    chk(exp_wr_busy == 6 && exp_rd_busy == 6, "R2 derived cycle counts", 32'(exp_wr_busy), 32'd6);
    pool = '{21'd0, 21'd1, 21'd5, 21'd6, 21'h0ABCD, 21'h100000, 21'h1FFFFE, 21'h1FFFFF};
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid && req_ready,
        "R1 strobes idle in reset", {26'd0, mem_cs_n, mem_we_n, mem_oe_n}, 32'h3F);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
        "R1 strobes idle after reset", {26'd0, mem_cs_n, mem_we_n, mem_oe_n}, 32'h3F);

    // directed corners
    do_write(21'h1FFFFF, 32'hDEAD_BEEF, 4'hF, 0);
    do_read (21'h1FFFFF, 4'hF, "R7 full word at top address");
    do_write(21'h1FFFFF, 32'h1122_3344, 4'b0101, 0);
    do_read (21'h1FFFFF, 4'hF, "R5 partial write keeps other bytes");
    do_read (21'h1FFFFF, 4'b1001, "R7 masked read zeroes lanes");
    do_write(21'd6, 32'h0BAD_F00D, 4'hF, 0);
    do_write(21'd5, 32'h5555_AAAA, 4'hF, 1);
    do_read (21'd6, 4'hF, "R11 request during busy ignored");
    do_write(21'd5, 32'h9999_9999, 4'h0, 0);
    do_read (21'd5, 4'hF, "R10 zero-lane write changes nothing");
    do_read (21'd5, 4'h0, "R10 zero-lane read");

    // seeded random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 60; i++) begin
      logic [20:0] a;
      logic [3:0]  ln;
      a  = pool[$urandom % 8];
      ln = 4'($urandom);
      if (($urandom % 2) == 0) do_write(a, $urandom, ln, 0);
      else                     do_read(a, ln, "R5 random read");
    end

    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule